// File: doc/BRIEF.md
# Pipelined Restoring Array Divider

This block divides an unsigned numerator by an unsigned denominator and returns both the quotient and the remainder. Inside it is a chain of identical restoring cells, one per quotient bit. The cell for the most significant bit comes first. Each cell shifts the next numerator bit into a running partial remainder. It then tests whether the denominator fits, writes the resulting quotient bit, and subtracts the denominator only when it fits. The last partial remainder is the remainder.

Registers can be placed between cells to trade latency for clock rate. `LATENCY` sets how many there are. `PLACE` sets the cell after which the first one sits. With zero registers the whole chain is combinational. If the denominator is known never to fall below a power of two, `MIN_DW` drops the leading cells, which could only ever produce zeros. This shortens both the chain and the quotient. All operands enter on every enabled clock edge and results leave in the same order. The block has no handshake. `ce` stalls the whole pipeline and `arst` empties it.

Top module: `restoring_divider`

## Requirements
- R1: When `den` is nonzero, `quo` equals the integer part of `num / den` and `rem` equals `num mod den`. Both operands are unsigned.
- R2: When `den` is zero, every bit of `quo` is 1 and `rem` equals the low `REM_W` bits of `num`.
- R3: With `LATENCY` = 0 the divider is purely combinational: the outputs follow the inputs within the same cycle, with no clock edge in between.
- R4: With `LATENCY` = L > 0 and `ce` held high, the operands present at one rising edge appear on the outputs after the L-th rising edge that follows. A new pair of operands is accepted on every enabled edge.
- R5: At a rising edge with `ce` low, every pipeline register keeps its value, so neither `quo` nor `rem` changes across that edge.
- R6: While `arst` is high, every pipeline register reads zero and `rem` reads zero. If a register follows the final cell, `quo` also reads zero. Otherwise the cells after the last register see a zero divisor, so each of their quotient bits reads 1 and every other quotient bit reads 0.
- R7: Cells are numbered from 0. Cell j produces quotient bit `QUO_W-1-j`. Register k, for k = 0..L-1, sits after cell `(QUO_W-1-PLACE+k) mod QUO_W`. The default `PLACE` is `QUO_W/2`, `PLACE` = 0 puts the first register after the last cell, and `PLACE` = `QUO_W-1` puts it after the first cell.
- R8: With `MIN_DW` > 1, the chain has `QUO_W = NUM_W-MIN_DW+1` cells. The partial remainder starts out holding the top `MIN_DW-1` numerator bits. R1 holds for every denominator at or above `2^(MIN_DW-1)`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the pipeline registers |
| arst | input | 1 | Asynchronous clear, active high, zeroes every pipeline register |
| ce | input | 1 | Clock enable; low freezes every pipeline register |
| num | input | NUM_W | Unsigned numerator |
| den | input | DEN_W | Unsigned denominator |
| quo | output | QUO_W | Quotient, `NUM_W-MIN_DW+1` bits |
| rem | output | REM_W | Remainder, the smaller of `NUM_W` and `DEN_W` bits |

## Verification
The output checks assume that a trimmed divider (`MIN_DW` > 1) never receives a denominator below `2^(MIN_DW-1)`. Under that assumption the identity `quo*den + rem == num` and the bound `rem < den` hold for the operand pair carried alongside each result. The zero-divisor check fires only after as many enabled edges since the clear as there are registers, because before that the cleared register contents are still visible at the outputs. The stimulus gives zero denominators only to the untrimmed instances. For the trimmed instance it draws the divisor from 4 to 63, which keeps that instance inside its assumption.

// File: rtl/restoring_divider_pkg.sv
package restoring_divider_pkg;

  // Smaller of two widths.
  function automatic int min_w(int a, int b);
    return (a < b) ? a : b;
  endfunction

  // True when a pipeline register follows cell j. The first register sits
  // after cell qw-1-place, and the others follow in chain order, wrapping
  // back to cell 0.
  function automatic bit reg_after(int j, int qw, int lat, int place);
    int first;
    first = qw - 1 - place;
    return ((j - first + qw) % qw) < lat;
  endfunction

endpackage

// File: rtl/rdiv_stage.sv
// One restoring cell: shift in a numerator bit, try the subtraction, keep
// the difference only when it does not borrow.
module rdiv_stage #(
  parameter int DEN_W = 8,
  parameter int QUO_W = 8,
  parameter int POS   = 0
) (
  input  logic [DEN_W-1:0] pr_i,
  input  logic             nbit_i,
  input  logic [DEN_W-1:0] den_i,
  input  logic [QUO_W-1:0] q_i,
  output logic [DEN_W-1:0] pr_o,
  output logic [QUO_W-1:0] q_o
);

  logic [DEN_W:0] shifted;
  logic           fits;

  always_comb begin
    shifted = {pr_i, nbit_i};
    fits    = shifted >= {1'b0, den_i};
    pr_o    = fits ? DEN_W'(shifted - {1'b0, den_i}) : shifted[DEN_W-1:0];
    q_o     = q_i | (QUO_W'(fits) << POS);
  end

endmodule

// File: rtl/rdiv_pipe_reg.sv
// Bundle register between two cells: asynchronous clear, clock enable.
module rdiv_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         arst,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or posedge arst) begin
    if (arst)    q <= '0;
    else if (ce) q <= d;
  end

  // R6: the clear empties the register
  a_r6_clear: assert property (@(posedge clk) arst |-> q == '0);

endmodule

// File: rtl/restoring_divider.sv
module restoring_divider
  import restoring_divider_pkg::*;
#(
  parameter int NUM_W   = 8,
  parameter int DEN_W   = 8,
  parameter int MIN_DW  = 1,
  parameter int QUO_W   = NUM_W - MIN_DW + 1,
  parameter int REM_W   = min_w(NUM_W, DEN_W),
  parameter int LATENCY = 0,
  parameter int PLACE   = QUO_W / 2
) (
  input  logic             clk,
  input  logic             arst,
  input  logic             ce,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [QUO_W-1:0] quo,
  output logic [REM_W-1:0] rem
);

  localparam int BW = DEN_W + NUM_W + DEN_W + QUO_W;  // bundle per boundary
  localparam int CW = $clog2(QUO_W + 1) + 1;           // fill counter width
  localparam int PW = NUM_W + DEN_W + 1;               // identity check width

  // Parameter legality
  if (QUO_W != NUM_W - MIN_DW + 1) begin : g_bad_quo
    $error("quotient width must be NUM_W - MIN_DW + 1");
  end
  if (REM_W != min_w(NUM_W, DEN_W)) begin : g_bad_rem
    $error("remainder width must be the smaller operand width");
  end
  if (MIN_DW < 1 || MIN_DW > min_w(NUM_W, DEN_W)) begin : g_bad_min
    $error("MIN_DW out of range");
  end
  if (LATENCY < 0 || LATENCY > QUO_W) begin : g_bad_lat
    $error("LATENCY must lie between 0 and QUO_W");
  end
  if (PLACE < 0 || PLACE > QUO_W - 1) begin : g_bad_place
    $error("PLACE must lie between 0 and QUO_W-1");
  end

  // Boundary b lies in front of cell b; boundary QUO_W is the output.
  logic [DEN_W-1:0] pr_b [QUO_W+1];
  logic [NUM_W-1:0] nm_b [QUO_W+1];
  logic [DEN_W-1:0] dn_b [QUO_W+1];
  logic [QUO_W-1:0] qt_b [QUO_W+1];

  // The leading MIN_DW-1 numerator bits start out as the partial remainder.
  assign pr_b[0] = DEN_W'({{DEN_W{1'b0}}, num} >> QUO_W);
  assign nm_b[0] = num;
  assign dn_b[0] = den;
  assign qt_b[0] = '0;

  for (genvar i = 0; i < QUO_W; i++) begin : g_cell
    localparam int POS = QUO_W - 1 - i;
    logic [DEN_W-1:0] st_pr;
    logic [QUO_W-1:0] st_q;

    rdiv_stage #(.DEN_W(DEN_W), .QUO_W(QUO_W), .POS(POS)) u_stage (
      .pr_i   (pr_b[i]),
      .nbit_i (nm_b[i][POS]),
      .den_i  (dn_b[i]),
      .q_i    (qt_b[i]),
      .pr_o   (st_pr),
      .q_o    (st_q)
    );

    if (reg_after(i, QUO_W, LATENCY, PLACE)) begin : g_reg
      rdiv_pipe_reg #(.W(BW)) u_reg (
        .clk  (clk),
        .arst (arst),
        .ce   (ce),
        .d    ({st_pr, nm_b[i], dn_b[i], st_q}),
        .q    ({pr_b[i+1], nm_b[i+1], dn_b[i+1], qt_b[i+1]})
      );
    end else begin : g_wire
      assign pr_b[i+1] = st_pr;
      assign nm_b[i+1] = nm_b[i];
      assign dn_b[i+1] = dn_b[i];
      assign qt_b[i+1] = st_q;
    end
  end

  assign quo = qt_b[QUO_W];
  assign rem = pr_b[QUO_W][REM_W-1:0];

  // ---------------------------------------------------------------------
  // Checks. The operand pair travels with its result, so the output can be
  // related to the operands that produced it.
  // ---------------------------------------------------------------------
  logic [CW-1:0] fill;
  logic          primed;
  logic [PW-1:0] chk_lhs, chk_rhs;

  always_ff @(posedge clk or posedge arst) begin
    if (arst)                          fill <= '0;
    else if (ce && fill < CW'(LATENCY)) fill <= fill + 1'b1;
  end

  always_comb begin
    primed  = fill >= CW'(LATENCY);
    chk_lhs = PW'(quo) * PW'(dn_b[QUO_W]) + PW'(rem);
    chk_rhs = PW'(nm_b[QUO_W]);
  end

  // R1: quotient and remainder rebuild the numerator
  a_r1_identity: assert property (@(posedge clk) disable iff (arst)
    (dn_b[QUO_W] != '0) |-> chk_lhs == chk_rhs);

  // R1: remainder stays under the divisor
  a_r1_rem_below_den: assert property (@(posedge clk) disable iff (arst)
    (dn_b[QUO_W] != '0) |-> DEN_W'(rem) < dn_b[QUO_W]);

  // R2: zero divisor gives all-ones quotient and passes the numerator through
  a_r2_zero_den: assert property (@(posedge clk) disable iff (arst)
    (primed && dn_b[QUO_W] == '0) |-> (quo == '1 && rem == nm_b[QUO_W][REM_W-1:0]));

  // R5: a disabled edge leaves the outputs untouched
  a_r5_hold: assert property (@(posedge clk) disable iff (arst)
    (LATENCY > 0 && !ce) |=> ($stable(quo) && $stable(rem)));

endmodule

// File: tb/restoring_divider_bench.sv
module restoring_divider_bench;

  localparam int NCFG = 5;
  typedef logic [15:0] item_t;

  logic       clk = 1'b0;
  logic       arst = 1'b1;
  logic       ce = 1'b0;
  logic [9:0] num10 = '0;
  logic [7:0] den8 = '0;
  logic [5:0] den6 = 6'd4;

  always #5 clk = ~clk;

  logic [7:0] qa, qb, qc, qd, qe;
  logic [7:0] ra, rb, rc, rd;
  logic [5:0] re;

  // A: combinational
  restoring_divider #(.NUM_W(8), .DEN_W(8), .LATENCY(0)) u_restoring_divider (
    .clk(clk), .arst(arst), .ce(ce), .num(num10[7:0]), .den(den8), .quo(qa), .rem(ra));
  // B: two registers, default placement
  restoring_divider #(.NUM_W(8), .DEN_W(8), .LATENCY(2)) u_restoring_divider_b (
    .clk(clk), .arst(arst), .ce(ce), .num(num10[7:0]), .den(den8), .quo(qb), .rem(rb));
  // C: a register after every cell
  restoring_divider #(.NUM_W(8), .DEN_W(8), .LATENCY(8), .PLACE(0)) u_restoring_divider_c (
    .clk(clk), .arst(arst), .ce(ce), .num(num10[7:0]), .den(den8), .quo(qc), .rem(rc));
  // D: three registers starting after the first cell
  restoring_divider #(.NUM_W(8), .DEN_W(8), .LATENCY(3), .PLACE(7)) u_restoring_divider_d (
    .clk(clk), .arst(arst), .ce(ce), .num(num10[7:0]), .den(den8), .quo(qd), .rem(rd));
  // E: trimmed array, divisor always at least 4
  restoring_divider #(.NUM_W(10), .DEN_W(6), .MIN_DW(3), .LATENCY(4), .PLACE(2))
    u_restoring_divider_e (
    .clk(clk), .arst(arst), .ce(ce), .num(num10), .den(den6), .quo(qe), .rem(re));

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  bit    started = 1'b0;
  bit    last_en = 1'b0;
  int    lat [NCFG] = '{0, 2, 8, 3, 4};
  item_t prev [NCFG];
  item_t sbq [NCFG][$];

  function automatic item_t out_of(int c);
    case (c)
      0:       return {qa, ra};
      1:       return {qb, rb};
      2:       return {qc, rc};
      3:       return {qd, rd};
      default: return {qe, 2'b00, re};
    endcase
  endfunction

  function automatic item_t expect_of(int c, logic [9:0] n, logic [7:0] d8, logic [5:0] d6);
    logic [9:0] q10, r10;
    logic [7:0] n8;
    if (c == 4) begin
      q10 = n / {4'b0000, d6};
      r10 = n % {4'b0000, d6};
      return {q10[7:0], 2'b00, r10[5:0]};
    end
    n8 = n[7:0];
    if (d8 == 8'd0) return {8'hFF, n8};
    return {n8 / d8, n8 % d8};
  endfunction

  task automatic check(string req, item_t act, item_t exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Driver: apply operands at the falling edge, record expectations at the
  // rising edge that takes them.
  task automatic drive(logic [9:0] n, logic [7:0] d8, logic [5:0] d6, logic en);
    @(negedge clk);
    num10 = n;
    den8  = d8;
    den6  = d6;
    ce    = en;
    #1;
    check((d8 == 8'd0) ? "R3 comb, R2 zero divisor" : "R3 comb, R1 quotient",
          out_of(0), expect_of(0, n, d8, d6));
    @(posedge clk);
    last_en = en;
    if (en) begin
      for (int c = 1; c < NCFG; c++) sbq[c].push_back(expect_of(c, n, d8, d6));
    end
  endtask

  // Monitor: compare registered outputs between edges.
  always @(negedge clk) begin
    if (started) begin
      for (int c = 1; c < NCFG; c++) begin
        if (last_en) begin
          if (sbq[c].size() == lat[c]) begin
            item_t exp_item;
            exp_item = sbq[c].pop_front();
            check((c == 4) ? "R8 trimmed, R4 latency" : "R4 latency, R1 result",
                  out_of(c), exp_item);
          end
        end else begin
          check("R5 hold on disabled edge", out_of(c), prev[c]);
        end
        prev[c] = out_of(c);
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // Clear state (R6, R7)
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 zero divisor during clear (comb)", out_of(0), {8'hFF, 8'h00});
    check("R6 R7 clear, regs after cells 3,4", out_of(1), {8'h07, 8'h00});
    check("R6 clear, output register", out_of(2), 16'h0000);
    check("R7 placement from first cell", out_of(3), {8'h1F, 8'h00});
    check("R6 R7 wrapped placement", out_of(4), 16'h0000);
    arst = 1'b0;
    @(negedge clk);
    for (int c = 1; c < NCFG; c++) prev[c] = out_of(c);
    started = 1'b1;

    // Directed corners, back to back
    drive(10'd0,    8'd0,   6'd4,  1'b1);
    drive(10'd200,  8'd0,   6'd5,  1'b1);
    drive(10'd255,  8'd1,   6'd4,  1'b1);
    drive(10'd255,  8'd255, 6'd63, 1'b1);
    drive(10'd17,   8'd34,  6'd4,  1'b1);
    drive(10'd100,  8'd100, 6'd50, 1'b1);
    drive(10'd1023, 8'd3,   6'd4,  1'b1);
    drive(10'd513,  8'd7,   6'd33, 1'b1);
    drive(10'd128,  8'd128, 6'd32, 1'b1);
    drive(10'd254,  8'd127, 6'd63, 1'b0);
    drive(10'd77,   8'd0,   6'd9,  1'b0);
    drive(10'd999,  8'd16,  6'd16, 1'b1);

    // Random traffic with stalls
    for (int k = 0; k < 400; k++) begin
      logic [9:0] n;
      logic [7:0] d8;
      logic [5:0] d6;
      logic       en;
      n  = 10'($urandom_range(0, 1023));
      d8 = ($urandom_range(0, 7) == 0) ? 8'd0 : 8'($urandom_range(1, 255));
      d6 = 6'($urandom_range(4, 63));
      en = ($urandom_range(0, 3) != 0);
      drive(n, d8, d6, en);
    end

    // Flush
    for (int k = 0; k < 10; k++) drive(10'd300, 8'd9, 6'd11, 1'b1);

    @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule